// File: doc/BRIEF.md
# Dual-Edge Two-Read Register File

This block holds thirty-two 32-bit words and serves two reads and one write in every clock cycle. A write is committed on the rising clock edge, and only when the write enable is high at that edge. Each read port has its own output register. On the falling edge, that register takes a copy of the word its address selects, so the read data moves only on falling edges.

Because the capture comes half a cycle after the write, a read of an entry in the same cycle as a write to it returns the new value. The read data does not follow the address combinationally. It stays constant from one falling edge to the next.

A synchronous clear acts on the falling edge and forces both output registers to zero. It gives a known output state at start-up. The clear never touches the stored words. The storage array itself has no reset, no entry is wired to zero, and there is no forwarding path from write to read.

Top module: `dual_edge_regfile`

## Requirements
- R1: The file has 32 entries of 32 bits, addressed by a 5-bit entry number. Every entry can be written and then read back unchanged.
- R2: The two read ports work independently in the same cycle. This holds whether the two read addresses are different or equal.
- R3: On each falling clock edge, each read output register loads the word at its current read address.
- R4: On a rising edge where `wr_en` is 1, the entry selected by `wr_addr` takes the value of `wr_data`.
- R5: On a rising edge where `wr_en` is 0, no entry changes, whatever `wr_addr` and `wr_data` hold.
- R6: A word written on a rising edge appears at a read port that addresses that entry on the falling edge of the same cycle.
- R7: Read outputs change only on falling edges. A new read address or a write has no effect on the outputs until the next falling edge.
- R8: When `srst` is 1 at a falling edge, both read outputs become zero. The stored entries are not affected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock. Writes happen on the rising edge; output capture happens on the falling edge. |
| srst | input | 1 | Synchronous clear of the read output registers, sampled on the falling edge. |
| rd_addr_a | input | 5 | Entry number for read port A. |
| rd_addr_b | input | 5 | Entry number for read port B. |
| wr_addr | input | 5 | Entry number to write. |
| wr_data | input | 32 | Word to write. |
| wr_en | input | 1 | Write enable, sampled on the rising edge. |
| rd_data_a | output | 32 | Registered read data of port A. |
| rd_data_b | output | 32 | Registered read data of port B. |

## Verification
Four properties are checked on every relevant edge:
- An enabled write lands in the addressed entry.
- Every entry that is not the write target holds its value across a rising edge.
- Each output register, one falling edge later, equals the word its port selected.
- A clear gives zero outputs.

The bench scenarios cover the rest. They show that the outputs are still unchanged at the rising edge that follows a new address or a write. They show the half-cycle write-to-read path, and reads of the same and of different entries against a model of the file. They also show that stored words survive a clear.

// File: rtl/rf_pkg.sv
package rf_pkg;
    parameter int RF_ADDR_W     = 5;
    parameter int RF_DATA_W     = 32;
    parameter int RF_READ_PORTS = 2;
endpackage

// File: rtl/rf_storage.sv
module rf_storage #(
    parameter int ADDR_W  = rf_pkg::RF_ADDR_W,
    parameter int DATA_W  = rf_pkg::RF_DATA_W,
    parameter int N_READ  = rf_pkg::RF_READ_PORTS
) (
    input  logic                           clk,
    input  logic                           srst,
    input  logic                           wr_en,
    input  logic [ADDR_W-1:0]              wr_addr,
    input  logic [DATA_W-1:0]              wr_data,
    input  logic [N_READ-1:0][ADDR_W-1:0]  rd_addr,
    output logic [N_READ-1:0][DATA_W-1:0]  rd_word
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Rising-edge storage; no reset on the array.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // One combinational selector per read port.
    for (genvar p = 0; p < N_READ; p++) begin : g_sel
        assign rd_word[p] = mem[rd_addr[p]];
    end

    // R4: an enabled write lands in the addressed entry.
    a_r4_write_lands: assert property (@(posedge clk) disable iff (srst)
        wr_en |=> mem[$past(wr_addr)] == $past(wr_data));

    // R5: an entry that is not written holds its value.
    for (genvar e = 0; e < DEPTH; e++) begin : g_hold
        a_r5_entry_held: assert property (@(posedge clk) disable iff (srst)
            (!wr_en || wr_addr != ADDR_W'(e)) |=> $stable(mem[e]));
    end
endmodule

// File: rtl/rf_read_port.sv
module rf_read_port #(
    parameter int DATA_W = rf_pkg::RF_DATA_W
) (
    input  logic              clk,
    input  logic              srst,
    input  logic [DATA_W-1:0] word,
    output logic [DATA_W-1:0] q
);
    // Output capture on the falling edge.
    always_ff @(negedge clk) begin
        if (srst) begin
            q <= '0;
        end else begin
            q <= word;
        end
    end

    // R3: the register holds the word selected one falling edge earlier.
    a_r3_capture: assert property (@(negedge clk) disable iff (srst)
        1'b1 |=> (srst || q == $past(word)));

    // R8: a clear yields a zero output.
    a_r8_clear_zero: assert property (@(negedge clk)
        srst |=> q == '0);
endmodule

// File: rtl/dual_edge_regfile.sv
module dual_edge_regfile #(
    parameter int ADDR_W = rf_pkg::RF_ADDR_W,
    parameter int DATA_W = rf_pkg::RF_DATA_W
) (
    input  logic              clk,
    input  logic              srst,
    input  logic [ADDR_W-1:0] rd_addr_a,
    input  logic [ADDR_W-1:0] rd_addr_b,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_en,
    output logic [DATA_W-1:0] rd_data_a,
    output logic [DATA_W-1:0] rd_data_b
);
    localparam int N_READ = 2;

    logic [N_READ-1:0][ADDR_W-1:0] rd_addr;
    logic [N_READ-1:0][DATA_W-1:0] rd_word;
    logic [N_READ-1:0][DATA_W-1:0] rd_q;

    assign rd_addr[0] = rd_addr_a;
    assign rd_addr[1] = rd_addr_b;

    rf_storage #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .N_READ (N_READ)
    ) u_store (
        .clk     (clk),
        .srst    (srst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_word (rd_word)
    );

    for (genvar p = 0; p < N_READ; p++) begin : g_port
        rf_read_port #(
            .DATA_W (DATA_W)
        ) u_port (
            .clk  (clk),
            .srst (srst),
            .word (rd_word[p]),
            .q    (rd_q[p])
        );
    end

    assign rd_data_a = rd_q[0];
    assign rd_data_b = rd_q[1];
endmodule

// File: tb/dual_edge_regfile_test.sv
module dual_edge_regfile_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        srst = 1'b1;
    logic [4:0]  rd_addr_a = '0, rd_addr_b = '0, wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        wr_en = 1'b0;
    logic [31:0] rd_data_a, rd_data_b;

    int checks = 0;
    int errors = 0;
    logic [31:0] model [32];

    dual_edge_regfile uut (
        .clk(clk), .srst(srst), .rd_addr_a(rd_addr_a), .rd_addr_b(rd_addr_b),
        .wr_addr(wr_addr), .wr_data(wr_data), .wr_en(wr_en),
        .rd_data_a(rd_data_a), .rd_data_b(rd_data_b)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] expect_rd(input logic [4:0] a, input bit rst);
        return rst ? 32'h0 : model[a];
    endfunction

    // Called at falling edge + 1. Runs one full cycle.
    task automatic step(input logic [4:0] ra, input logic [4:0] rb, input logic [4:0] wa,
                        input logic [31:0] wd, input bit we, input bit rst);
        logic [31:0] pa, pb;
        string ta, tb;
        pa = rd_data_a;
        pb = rd_data_b;
        rd_addr_a = ra; rd_addr_b = rb; wr_addr = wa; wr_data = wd; wr_en = we; srst = rst;
        @(posedge clk); #1;
        chk("R7 port A held at rising edge", rd_data_a, pa);
        chk("R7 port B held at rising edge", rd_data_b, pb);
        if (we) model[wa] = wd;
        @(negedge clk); #1;
        ta = rst ? "R8" : (we && wa == ra) ? "R6" : (ra == rb) ? "R2" : "R3";
        tb = rst ? "R8" : (we && wa == rb) ? "R6" : (ra == rb) ? "R2" : "R3";
        chk({ta, " port A"}, rd_data_a, expect_rd(ra, rst));
        chk({tb, " port B"}, rd_data_b, expect_rd(rb, rst));
    endtask

    initial begin
        logic [31:0] seed_val;
        seed_val = $urandom(32'h5EED_1234);
        @(negedge clk); #1;
        // R8: outputs cleared while storage is loaded
        for (int i = 0; i < 32; i++) begin
            step(5'(i), 5'(31 - i), 5'(i), 32'hA5000000 ^ (32'(i) * 32'h01010101), 1'b1, 1'b1);
        end
        // R1: read back every entry, pairs of different addresses
        for (int i = 0; i < 32; i++) begin
            step(5'(i), 5'(31 - i), 5'd0, 32'h0, 1'b0, 1'b0);
        end
        // R2: both ports on the same entry
        step(5'd9, 5'd9, 5'd0, 32'h0, 1'b0, 1'b0);
        // R4/R6: write then same-cycle read on both ports
        step(5'd12, 5'd12, 5'd12, 32'hDEADBEEF, 1'b1, 1'b0);
        // R5: disabled write to entry 12 must leave it intact
        step(5'd3, 5'd4, 5'd12, 32'h12345678, 1'b0, 1'b0);
        step(5'd12, 5'd3, 5'd0, 32'h0, 1'b0, 1'b0);
        chk("R5 entry 12 intact", rd_data_a, 32'hDEADBEEF);
        // R8: clear mid-run, storage preserved
        step(5'd12, 5'd31, 5'd0, 32'h0, 1'b0, 1'b1);
        step(5'd12, 5'd31, 5'd0, 32'h0, 1'b0, 1'b0);
        chk("R8 storage kept after clear", rd_data_a, 32'hDEADBEEF);
        // Constrained random mix
        for (int n = 0; n < 400; n++) begin
            logic [4:0] ra, rb, wa;
            logic [31:0] wd;
            bit we;
            ra = 5'($urandom % 32);
            rb = ($urandom % 4 == 0) ? ra : 5'($urandom % 32);
            wa = ($urandom % 3 == 0) ? ra : 5'($urandom % 32);
            wd = $urandom;
            we = ($urandom % 2) == 1;
            step(ra, rb, wa, wd, we, ($urandom % 40) == 0);
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule